// File: doc/BRIEF.md
# CAN Transmit Mailbox Priority Selector

This block decides which of the sixteen mailboxes of a CAN controller feeds the single transmit buffer. Mailbox 0 serves reception only. Mailboxes 1 to 15 can each be marked for reception. Any mailbox that is not excluded and has its request bit set is a candidate.

A policy input picks the winner among the candidates in one of two ways:
- **Mailbox-number policy:** the lowest mailbox number wins.
- **Identifier policy:** the mailbox whose identifier would win CAN bus arbitration wins.

The selection is registered and recomputed every clock, so a newly raised request is taken into account one cycle later.

After the bus has been won, the buffer is frozen until the frame is done. At that point the block emits a one-hot strobe so the owner of the request bits can clear the finished request. Mailbox contents arrive as flat register inputs.

Top module: `txmb_select`

## Requirements
- R1: While `rst_n` is low and in the first cycle after release, `sel_valid`, `sel_locked` and `pend_clr` are all zero and `sel_idx` is 0.
- R2: Mailbox 0 is never reported as selected, whatever `tx_pend[0]` and `rx_cfg[0]` hold.
- R3: A mailbox whose `rx_cfg` bit is 1 is never selected. When no mailbox is eligible (eligible means pending with `rx_cfg` = 0, index 1 or higher) and the buffer is not locked, `sel_valid` is 0 one cycle later.
- R4: With `by_id_mode` = 0, the lowest-numbered eligible mailbox is selected.
- R5: With `by_id_mode` = 1, the eligible mailbox with the smallest priority key is selected.
  - The key compares `base` first, then the extended flag (0 = standard wins), then `xid`.
  - `xid` takes part only for extended frames, so a standard frame beats an extended one with the same base.
- R6: Mailboxes with equal keys resolve to the lower mailbox number.
- R7: While unlocked, `sel_idx`, `sel_base`, `sel_xid`, `sel_ext` and `sel_valid` reflect the inputs present one clock edge earlier. The loaded fields are that mailbox's stored values.
- R8: `bus_won` while `sel_valid` is 1 sets `sel_locked` at the next edge. While locked and `tx_done` is 0, all selection outputs hold regardless of input changes.
- R9: `tx_done` while locked drives `pend_clr` one-hot at bit `sel_idx` in that same cycle. At the next edge it clears `sel_valid` and `sel_locked`.
- R10: `tx_done` while unlocked leaves `pend_clr` zero and causes no lock. `bus_won` while `sel_valid` is 0 causes no lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_pend | input | NUM_MB | Transmit request bit per mailbox |
| rx_cfg | input | NUM_MB | 1 = mailbox reserved for reception |
| by_id_mode | input | 1 | 1 = identifier policy, 0 = mailbox-number policy |
| mb_base | input | NUM_MB*BASE_W | Base identifier per mailbox, mailbox i at slice i |
| mb_xid | input | NUM_MB*XID_W | Extended identifier bits per mailbox |
| mb_ext | input | NUM_MB | 1 = extended frame |
| bus_won | input | 1 | Bus arbitration won for the buffered frame |
| tx_done | input | 1 | Buffered frame finished |
| sel_valid | output | 1 | Buffer holds a selected mailbox |
| sel_idx | output | IDX_W | Selected mailbox number |
| sel_base | output | BASE_W | Loaded base identifier |
| sel_xid | output | XID_W | Loaded extended identifier bits |
| sel_ext | output | 1 | Loaded extended flag |
| sel_locked | output | 1 | Buffer frozen during transmission |
| pend_clr | output | NUM_MB | One-hot request-clear strobe |

## Verification
The bench builds the block at its default sizes: sixteen mailboxes, 11-bit base and 18-bit extended fields. Random identifiers are drawn from a handful of values only. This makes equal keys and standard-against-extended collisions on a shared base frequent, so the tie-break and the frame-format rule are exercised often rather than by rare chance. Lock and release sequences are interleaved with random input changes, to show that the frozen buffer ignores them.

// File: rtl/txmb_pkg.sv
// Shared types for the transmit mailbox selector.
// Assumes nothing beyond the two selection policies.
package txmb_pkg;
    typedef enum logic {
        POL_MBNUM = 1'b0,
        POL_IDENT = 1'b1
    } sel_pol_e;
endpackage

// File: rtl/txmb_key.sv
// Per-mailbox eligibility flag and arbitration key builder.
// Assumes mailbox 0 is receive-only; key = {base, ext, ext ? xid : 0}
// so a smaller key is a higher bus priority.
module txmb_key #(
    parameter int NUM_MB = 16,
    parameter int BASE_W = 11,
    parameter int XID_W  = 18,
    localparam int KEY_W = BASE_W + 1 + XID_W
) (
    input  logic [NUM_MB-1:0]        tx_pend,
    input  logic [NUM_MB-1:0]        rx_cfg,
    input  logic [NUM_MB*BASE_W-1:0] mb_base,
    input  logic [NUM_MB*XID_W-1:0]  mb_xid,
    input  logic [NUM_MB-1:0]        mb_ext,
    output logic [NUM_MB-1:0]        elig,
    output logic [NUM_MB*KEY_W-1:0]  keys
);
    for (genvar g = 0; g < NUM_MB; g++) begin : g_mb
        if (g == 0) begin : g_rx_only
            // mailbox 0 never transmits
            assign elig[g] = 1'b0;
        end else begin : g_txable
            // pending and not reserved for reception
            assign elig[g] = tx_pend[g] & ~rx_cfg[g];
        end
        // standard frames ignore the extended bits
        assign keys[g*KEY_W +: KEY_W] =
            {mb_base[g*BASE_W +: BASE_W], mb_ext[g],
             mb_ext[g] ? mb_xid[g*XID_W +: XID_W] : {XID_W{1'b0}}};
    end
endmodule

// File: rtl/txmb_pick.sv
// Reduction over eligible mailboxes: lowest number, or smallest key.
// Scans upward with strict compare so ties keep the lower number.
module txmb_pick
    import txmb_pkg::*;
#(
    parameter int NUM_MB = 16,
    parameter int KEY_W  = 30,
    localparam int IDX_W = $clog2(NUM_MB)
) (
    input  logic [NUM_MB-1:0]       elig,
    input  logic [NUM_MB*KEY_W-1:0] keys,
    input  sel_pol_e                pol,
    output logic                    found,
    output logic [IDX_W-1:0]        idx
);
    logic [KEY_W-1:0] best_key;

    // linear scan keeping the current best candidate
    always_comb begin
        found    = 1'b0;
        idx      = '0;
        best_key = '0;
        for (int i = 0; i < NUM_MB; i++) begin
            if (elig[i]) begin
                if (!found || (pol == POL_IDENT &&
                               keys[i*KEY_W +: KEY_W] < best_key)) begin
                    found    = 1'b1;
                    idx      = IDX_W'(i);
                    best_key = keys[i*KEY_W +: KEY_W];
                end
            end
        end
    end
endmodule

// File: rtl/txmb_select.sv
// Transmit buffer loader: registers the winning mailbox each cycle,
// freezes it once the bus is won and releases it on completion.
// Assumes request bits are owned outside and cleared via pend_clr.
module txmb_select
    import txmb_pkg::*;
#(
    parameter int NUM_MB = 16,
    parameter int BASE_W = 11,
    parameter int XID_W  = 18,
    localparam int IDX_W = $clog2(NUM_MB),
    localparam int KEY_W = BASE_W + 1 + XID_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_MB-1:0]        tx_pend,
    input  logic [NUM_MB-1:0]        rx_cfg,
    input  logic                     by_id_mode,
    input  logic [NUM_MB*BASE_W-1:0] mb_base,
    input  logic [NUM_MB*XID_W-1:0]  mb_xid,
    input  logic [NUM_MB-1:0]        mb_ext,
    input  logic                     bus_won,
    input  logic                     tx_done,
    output logic                     sel_valid,
    output logic [IDX_W-1:0]         sel_idx,
    output logic [BASE_W-1:0]        sel_base,
    output logic [XID_W-1:0]         sel_xid,
    output logic                     sel_ext,
    output logic                     sel_locked,
    output logic [NUM_MB-1:0]        pend_clr
);
    logic [NUM_MB-1:0]       elig;
    logic [NUM_MB*KEY_W-1:0] keys;
    logic                    pick_found;
    logic [IDX_W-1:0]        pick_idx;

    txmb_key #(.NUM_MB(NUM_MB), .BASE_W(BASE_W), .XID_W(XID_W)) u_key (
        .tx_pend(tx_pend), .rx_cfg(rx_cfg), .mb_base(mb_base),
        .mb_xid(mb_xid), .mb_ext(mb_ext), .elig(elig), .keys(keys)
    );

    txmb_pick #(.NUM_MB(NUM_MB), .KEY_W(KEY_W)) u_pick (
        .elig(elig), .keys(keys), .pol(sel_pol_e'(by_id_mode)),
        .found(pick_found), .idx(pick_idx)
    );

    // selection register: reload, freeze or release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_valid  <= 1'b0;
            sel_idx    <= '0;
            sel_base   <= '0;
            sel_xid    <= '0;
            sel_ext    <= 1'b0;
            sel_locked <= 1'b0;
        end else if (sel_locked) begin
            if (tx_done) begin
                sel_locked <= 1'b0;
                sel_valid  <= 1'b0;
            end
        end else if (bus_won && sel_valid) begin
            sel_locked <= 1'b1;
        end else begin
            sel_valid <= pick_found;
            sel_idx   <= pick_idx;
            sel_base  <= mb_base[pick_idx*BASE_W +: BASE_W];
            sel_xid   <= mb_xid[pick_idx*XID_W +: XID_W];
            sel_ext   <= mb_ext[pick_idx];
        end
    end

    // completion strobe toward the request-bit owner
    always_comb begin
        pend_clr = '0;
        if (sel_locked && tx_done) pend_clr[sel_idx] = 1'b1;
    end
endmodule

// File: rtl/txmb_check.sv
// Protocol checker for txmb_select, attached by bind below.
module txmb_check #(
    parameter int NUM_MB = 16,
    localparam int IDX_W = $clog2(NUM_MB)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_MB-1:0] tx_pend,
    input logic [NUM_MB-1:0] rx_cfg,
    input logic              bus_won,
    input logic              tx_done,
    input logic              sel_valid,
    input logic [IDX_W-1:0]  sel_idx,
    input logic              sel_locked,
    input logic [NUM_MB-1:0] pend_clr
);
    logic [NUM_MB-1:0] elig_q;
    logic              locked_q;

    // previous-cycle eligibility and lock state
    always_ff @(posedge clk) begin
        elig_q   <= tx_pend & ~rx_cfg & ~NUM_MB'(1);
        locked_q <= sel_locked;
    end

    a_r2_no_mb0: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> sel_idx != '0);
    a_r3_was_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && !sel_locked) |-> elig_q[sel_idx]);
    a_r3_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (elig_q == '0 && !locked_q) |-> !sel_valid);
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_locked && !tx_done) |=> sel_locked && sel_valid && $stable(sel_idx));
    a_r9_clr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pend_clr));
    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_locked && tx_done) |=> !sel_valid && !sel_locked);
    a_r10_clr_only_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_clr != '0) |-> (sel_locked && tx_done));
    a_r10_lock_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_locked && !(bus_won && sel_valid)) |=> !sel_locked);
endmodule

bind txmb_select txmb_check #(.NUM_MB(NUM_MB)) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_pend(tx_pend), .rx_cfg(rx_cfg),
    .bus_won(bus_won), .tx_done(tx_done), .sel_valid(sel_valid),
    .sel_idx(sel_idx), .sel_locked(sel_locked), .pend_clr(pend_clr)
);

// File: tb/txmb_select_test.sv
`timescale 1ns/1ps
// Self-checking bench: directed corners plus seeded random traffic.
module txmb_select_test;
    localparam int NMB = 16;
    localparam int BW  = 11;
    localparam int XW  = 18;
    localparam int IW  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NMB-1:0] tx_pend = '0, rx_cfg = '0, mb_ext = '0;
    logic by_id_mode = 1'b0, bus_won = 1'b0, tx_done = 1'b0;
    logic [NMB*BW-1:0] mb_base = '0;
    logic [NMB*XW-1:0] mb_xid = '0;
    logic sel_valid, sel_ext, sel_locked;
    logic [IW-1:0] sel_idx;
    logic [BW-1:0] sel_base;
    logic [XW-1:0] sel_xid;
    logic [NMB-1:0] pend_clr;

    logic [BW-1:0] bases [NMB];
    logic [XW-1:0] xids  [NMB];
    int checks = 0, errors = 0;
    bit done_flag = 0;

    txmb_select uut (
        .clk(clk), .rst_n(rst_n), .tx_pend(tx_pend), .rx_cfg(rx_cfg),
        .by_id_mode(by_id_mode), .mb_base(mb_base), .mb_xid(mb_xid),
        .mb_ext(mb_ext), .bus_won(bus_won), .tx_done(tx_done),
        .sel_valid(sel_valid), .sel_idx(sel_idx), .sel_base(sel_base),
        .sel_xid(sel_xid), .sel_ext(sel_ext), .sel_locked(sel_locked),
        .pend_clr(pend_clr)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pack();
        for (int i = 0; i < NMB; i++) begin
            mb_base[i*BW +: BW] = bases[i];
            mb_xid[i*XW +: XW]  = xids[i];
        end
    endtask

    function automatic logic [BW+XW:0] key_of(input int i);
        return {bases[i], mb_ext[i], mb_ext[i] ? xids[i] : {XW{1'b0}}};
    endfunction

    // expected winner from the requirements R2..R6
    task automatic ref_pick(output bit f, output int idx);
        f = 0; idx = 0;
        for (int i = 1; i < NMB; i++)
            if (tx_pend[i] && !rx_cfg[i])
                if (!f || (by_id_mode && key_of(i) < key_of(idx))) begin
                    f = 1; idx = i;
                end
    endtask

    // one unlocked step: outputs after the edge must match the model
    task automatic step_check(input string tag);
        bit f; int e;
        ref_pick(f, e);
        @(posedge clk); #1;
        chk(sel_valid == f, {tag, " valid"}, sel_valid, f);
        if (f) begin
            chk(sel_idx == IW'(e), {tag, " idx"}, sel_idx, e);
            chk(sel_base == bases[e] && sel_xid == xids[e] && sel_ext == mb_ext[e],
                {tag, " R7 fields"}, sel_base, bases[e]);
        end
        chk(!(sel_valid && sel_idx == 0), "R2 mb0", sel_idx, 1);
        @(negedge clk);
    endtask

    task automatic randomize_mbx();
        for (int i = 0; i < NMB; i++) begin
            bases[i] = BW'($urandom % 4);
            xids[i]  = XW'($urandom % 3);
        end
        mb_ext  = NMB'($urandom);
        tx_pend = NMB'($urandom);
        rx_cfg  = NMB'($urandom) & NMB'($urandom);
        by_id_mode = 1'($urandom);
        pack();
    endtask

    // lock, hold under changes, then complete
    task automatic lock_cycle();
        logic [IW-1:0] held;
        logic [BW-1:0] hb;
        held = sel_idx; hb = sel_base;
        bus_won = 1'b1;
        @(posedge clk); #1;
        chk(sel_locked && sel_valid, "R8 lock", sel_locked, 1);
        @(negedge clk);
        bus_won = 1'b0;
        randomize_mbx();
        tx_pend[held] = 1'b1;
        @(posedge clk); #1;
        chk(sel_locked && sel_idx == held && sel_base == hb, "R8 hold", sel_idx, held);
        @(negedge clk);
        tx_done = 1'b1; #1;
        chk(pend_clr == (NMB'(1) << held), "R9 clr", pend_clr, NMB'(1) << held);
        @(posedge clk); #1;
        chk(!sel_valid && !sel_locked, "R9 release", {sel_valid, sel_locked}, 0);
        @(negedge clk);
        tx_done = 1'b0;
        tx_pend[held] = 1'b0;
        step_check("R7 reselect");
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < NMB; i++) begin bases[i] = '0; xids[i] = '0; end
        pack();
        repeat (3) @(posedge clk);
        #1;
        chk(!sel_valid && !sel_locked && pend_clr == 0 && sel_idx == 0, "R1 reset", sel_valid, 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk(!sel_valid && !sel_locked, "R1 after release", sel_valid, 0);
        @(negedge clk);

        // R2: only mailbox 0 requests
        tx_pend = 16'h0001; step_check("R2 only mb0");
        // R3: all requesters reserved for reception
        tx_pend = 16'h00F0; rx_cfg = 16'h00F0; step_check("R3 rx excluded");
        // R4: mailbox-number policy
        rx_cfg = '0; tx_pend = 16'h0088; bases[3] = 11'h200; bases[7] = 11'h010; pack();
        by_id_mode = 0; step_check("R4 number");
        // R5: identifier policy
        by_id_mode = 1; step_check("R5 ident");
        // R5: standard beats extended with same base, even at higher number
        tx_pend = 16'h0024; bases[2] = 11'h55; bases[5] = 11'h55;
        mb_ext = 16'h0004; xids[2] = '0; xids[5] = 18'h3FFFF; pack();
        step_check("R5 std over ext");
        // R6: equal keys resolve to lower number
        tx_pend = 16'h0A00; bases[9] = 11'h7; bases[11] = 11'h7; mb_ext = '0; pack();
        step_check("R6 tie");
        // R10: done while unlocked is ignored
        tx_done = 1'b1; #1;
        chk(pend_clr == 0, "R10 done unlocked", pend_clr, 0);
        @(posedge clk); #1;
        chk(!sel_locked, "R10 no lock on done", sel_locked, 0);
        @(negedge clk); tx_done = 1'b0;
        // R10: bus_won with nothing selected
        tx_pend = '0; step_check("R3 none");
        bus_won = 1'b1;
        @(posedge clk); #1;
        chk(!sel_locked && !sel_valid, "R10 won without valid", sel_locked, 0);
        @(negedge clk); bus_won = 1'b0;

        for (int n = 0; n < 400; n++) begin
            randomize_mbx();
            step_check("R4 R5 random");
            if (sel_valid && (n % 4 == 0)) lock_cycle();
        end

        if (!done_flag) begin
            done_flag = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 100000);
        if (!done_flag) begin
            done_flag = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule